// File: doc/BRIEF.md
# Selectable-Depth Sample Averager

This block takes a stream of 12-bit conversion results and returns their arithmetic mean over a chosen number of samples. Each input sample comes with a valid strobe and a channel tag. A 2-bit averaging code picks the depth. Code `00` passes each sample straight through. Codes `01`, `10` and `11` average over 16, 64 or 256 samples. The mean is the running sum shifted right by log2 of the depth, with truncation. The accumulator is 20 bits wide, so a full run of 256 full-scale samples never wraps.

One tag value (8 by default) marks samples for the calibration-coefficient path. That path ignores the averaging code. It averages exactly 16 samples unless a calibration-averaging disable input is high, in which case each calibration sample passes through alone. The same depth rule applies whether one channel is converted over and over or the tag changes between runs. Any change of the averaging code, the tag or the disable input throws away the partial sum. The sample that arrives in that same cycle then counts as the first of a new run.

Each completed run gives one registered result, a one-cycle valid pulse and the tag of the run. The result appears in the cycle after the run's last sample, and the accumulator clears at that same point.

Top module: `smp_avg_top`

## Requirements
- R1: While `rst_n` is low, `res_vld_o`, `res_data_o` and `res_tag_o` are 0. A partial sum taken before reset does not carry into the first run after it.
- R2: With `avg_mode_i` = 00 and a tag other than 8, every valid sample appears unchanged on `res_data_o` in the next cycle, with `res_vld_o` high.
- R3: With `avg_mode_i` = 01 on a non-calibration tag, `res_vld_o` pulses only in the cycle after every 16th valid sample. `res_data_o` is then floor(sum of those 16 / 16).
- R4: With `avg_mode_i` = 10 on a non-calibration tag, a result follows every 64th valid sample and equals floor(sum / 64).
- R5: With `avg_mode_i` = 11 on a non-calibration tag, a result follows every 256th valid sample and equals floor(sum / 256). 256 samples of 4095 give 4095.
- R6: Samples tagged 8 with `cal_avg_off_i` = 0 are averaged over 16 samples, whatever `avg_mode_i` holds.
- R7: Samples tagged 8 with `cal_avg_off_i` = 1 pass through one by one, whatever `avg_mode_i` holds.
- R8: Cycles with `smp_vld_i` low neither add to the count nor raise `res_vld_o`. `res_vld_o` is high only in the cycle after a valid sample.
- R9: A change of `avg_mode_i`, `smp_tag_i` or `cal_avg_off_i` discards the partial sum. The sample of that cycle starts a fresh run, so on a depth above 1 no result follows it.
- R10: `res_tag_o` carries the tag of the sample that completed the run.
- R11: On a non-calibration tag, `cal_avg_off_i` = 1 does not change the depth chosen by `avg_mode_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Sample valid strobe |
| smp_data_i | input | 12 | Conversion result |
| smp_tag_i | input | 5 | Channel tag of the sample; 8 selects the calibration path |
| avg_mode_i | input | 2 | Averaging code: 00 none, 01 16, 10 64, 11 256 samples |
| cal_avg_off_i | input | 1 | Turns off averaging on the calibration path |
| res_vld_o | output | 1 | One-cycle result valid pulse |
| res_data_o | output | 12 | Averaged result |
| res_tag_o | output | 5 | Tag of the run that produced the result |

## Verification
The properties assume that the tag, averaging code and disable input are driven to defined values while reset is held. The restart property compares the present tag with that of the previous edge. The pass-through properties assume the sample data is stable on the edge where it is taken. The bench changes every input only on the falling clock edge and holds all of them defined from time zero. It changes the configuration only between runs, or on purpose in the middle of one, to exercise the discard rule.

// File: rtl/smp_avg_pkg.sv
package smp_avg_pkg;
  localparam int unsigned SMP_W_DEF   = 12;
  localparam int unsigned TAG_W_DEF   = 5;
  localparam int unsigned CAL_TAG_DEF = 8;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'b00,
    MODE_DEP_A  = 2'b01,
    MODE_DEP_B  = 2'b10,
    MODE_DEP_C  = 2'b11
  } avg_mode_e;
endpackage

// File: rtl/smp_avg_cfg.sv
module smp_avg_cfg
  import smp_avg_pkg::*;
#(
  parameter int unsigned TAG_W    = 5,
  parameter int unsigned CAL_TAG  = 8,
  parameter int unsigned LOG2_A   = 4,
  parameter int unsigned LOG2_B   = 6,
  parameter int unsigned LOG2_C   = 8,
  parameter int unsigned LOG2_CAL = 4,
  parameter int unsigned SH_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             cal_off_i,
  output logic [SH_W-1:0]  shift_o,
  output logic             restart_o
);
  logic [1:0]       mode_q;
  logic [TAG_W-1:0] tag_q;
  logic             off_q;
  logic             cfg_chg;
  logic             is_cal;

  always_comb begin
    cfg_chg   = (mode_i != mode_q) || (tag_i != tag_q) || (cal_off_i != off_q);
    restart_o = cfg_chg;
    is_cal    = (tag_i == TAG_W'(CAL_TAG));
  end

  // depth selection: calibration tag overrides the mode code
  always_comb begin
    if (is_cal) begin
      shift_o = cal_off_i ? '0 : SH_W'(LOG2_CAL);
    end else begin
      unique case (avg_mode_e'(mode_i))
        MODE_BYPASS: shift_o = '0;
        MODE_DEP_A:  shift_o = SH_W'(LOG2_A);
        MODE_DEP_B:  shift_o = SH_W'(LOG2_B);
        MODE_DEP_C:  shift_o = SH_W'(LOG2_C);
        default:     shift_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      tag_q  <= '0;
      off_q  <= 1'b0;
    end else if (cfg_chg) begin
      mode_q <= mode_i;
      tag_q  <= tag_i;
      off_q  <= cal_off_i;
    end
  end
endmodule

// File: rtl/smp_avg_acc.sv
module smp_avg_acc #(
  parameter int unsigned SMP_W = 12,
  parameter int unsigned ACC_W = 20,
  parameter int unsigned CNT_W = 9,
  parameter int unsigned SH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [SMP_W-1:0] data_i,
  input  logic             restart_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic             done_o,
  output logic [ACC_W-1:0] sum_o
);
  logic [ACC_W-1:0] acc_q, acc_base, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_inc, cnt_d;
  logic             acc_en;

  always_comb begin
    acc_base = restart_i ? '0 : acc_q;
    cnt_base = restart_i ? '0 : cnt_q;
    sum_o    = acc_base + ACC_W'(data_i);
    cnt_inc  = cnt_base + CNT_W'(1);
    done_o   = vld_i && (cnt_inc == (CNT_W'(1) << shift_i));
    acc_en   = vld_i || restart_i;
    if (done_o) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (vld_i) begin
      acc_d = sum_o;
      cnt_d = cnt_inc;
    end else begin
      acc_d = acc_base;
      cnt_d = cnt_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/smp_avg_out.sv
module smp_avg_out #(
  parameter int unsigned SMP_W = 12,
  parameter int unsigned ACC_W = 20,
  parameter int unsigned TAG_W = 5,
  parameter int unsigned SH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic [ACC_W-1:0] sum_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             vld_o,
  output logic [SMP_W-1:0] data_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [ACC_W-1:0] shifted;
  logic [SMP_W-1:0] data_d;

  always_comb begin
    shifted = sum_i >> shift_i;
    data_d  = shifted[SMP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= done_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      tag_o  <= '0;
    end else if (done_i) begin
      data_o <= data_d;
      tag_o  <= tag_i;
    end
  end
endmodule

// File: rtl/smp_avg_top.sv
module smp_avg_top
  import smp_avg_pkg::*;
#(
  parameter int unsigned SMP_W    = SMP_W_DEF,
  parameter int unsigned TAG_W    = TAG_W_DEF,
  parameter int unsigned CAL_TAG  = CAL_TAG_DEF,
  parameter int unsigned LOG2_A   = 4,
  parameter int unsigned LOG2_B   = 6,
  parameter int unsigned LOG2_C   = 8,
  parameter int unsigned LOG2_CAL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] smp_data_i,
  input  logic [TAG_W-1:0] smp_tag_i,
  input  logic [1:0]       avg_mode_i,
  input  logic             cal_avg_off_i,
  output logic             res_vld_o,
  output logic [SMP_W-1:0] res_data_o,
  output logic [TAG_W-1:0] res_tag_o
);
  localparam int unsigned MAX_AB   = (LOG2_A > LOG2_B) ? LOG2_A : LOG2_B;
  localparam int unsigned MAX_ABC  = (MAX_AB > LOG2_C) ? MAX_AB : LOG2_C;
  localparam int unsigned MAX_LOG2 = (MAX_ABC > LOG2_CAL) ? MAX_ABC : LOG2_CAL;
  localparam int unsigned ACC_W    = SMP_W + MAX_LOG2;
  localparam int unsigned CNT_W    = MAX_LOG2 + 1;
  localparam int unsigned SH_W     = $clog2(MAX_LOG2 + 1);

  logic [SH_W-1:0]  shift;
  logic             restart;
  logic             done;
  logic [ACC_W-1:0] sum;

  smp_avg_cfg #(
    .TAG_W(TAG_W), .CAL_TAG(CAL_TAG), .LOG2_A(LOG2_A), .LOG2_B(LOG2_B),
    .LOG2_C(LOG2_C), .LOG2_CAL(LOG2_CAL), .SH_W(SH_W)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .mode_i(avg_mode_i), .tag_i(smp_tag_i),
    .cal_off_i(cal_avg_off_i), .shift_o(shift), .restart_o(restart)
  );

  smp_avg_acc #(
    .SMP_W(SMP_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .SH_W(SH_W)
  ) acc_i (
    .clk(clk), .rst_n(rst_n), .vld_i(smp_vld_i), .data_i(smp_data_i),
    .restart_i(restart), .shift_i(shift), .done_o(done), .sum_o(sum)
  );

  smp_avg_out #(
    .SMP_W(SMP_W), .ACC_W(ACC_W), .TAG_W(TAG_W), .SH_W(SH_W)
  ) out_i (
    .clk(clk), .rst_n(rst_n), .done_i(done), .sum_i(sum), .shift_i(shift),
    .tag_i(smp_tag_i), .vld_o(res_vld_o), .data_o(res_data_o), .tag_o(res_tag_o)
  );
endmodule

// File: rtl/smp_avg_chk.sv
module smp_avg_chk #(
  parameter int unsigned SMP_W   = 12,
  parameter int unsigned TAG_W   = 5,
  parameter int unsigned CAL_TAG = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_vld_i,
  input logic [SMP_W-1:0] smp_data_i,
  input logic [TAG_W-1:0] smp_tag_i,
  input logic [1:0]       avg_mode_i,
  input logic             cal_avg_off_i,
  input logic             res_vld_o,
  input logic [SMP_W-1:0] res_data_o,
  input logic [TAG_W-1:0] res_tag_o
);
  AST_BYPASS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && avg_mode_i == 2'b00 && smp_tag_i != TAG_W'(CAL_TAG))
      |=> (res_vld_o && res_data_o == $past(smp_data_i))); // R2

  AST_CAL_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && smp_tag_i == TAG_W'(CAL_TAG) && cal_avg_off_i)
      |=> (res_vld_o && res_data_o == $past(smp_data_i))); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld_i |=> !res_vld_o); // R8

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && avg_mode_i != 2'b00 && smp_tag_i != TAG_W'(CAL_TAG)
      && smp_tag_i != $past(smp_tag_i)) |=> !res_vld_o); // R9

  AST_TAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> res_tag_o == $past(smp_tag_i)); // R10
endmodule

bind smp_avg_top smp_avg_chk #(
  .SMP_W(SMP_W), .TAG_W(TAG_W), .CAL_TAG(CAL_TAG)
) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld_i), .smp_data_i(smp_data_i),
  .smp_tag_i(smp_tag_i), .avg_mode_i(avg_mode_i), .cal_avg_off_i(cal_avg_off_i),
  .res_vld_o(res_vld_o), .res_data_o(res_data_o), .res_tag_o(res_tag_o)
);

// File: tb/smp_avg_top_tb_top.sv
`timescale 1ns/1ps
module smp_avg_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_vld;
  logic [11:0] smp_data;
  logic [4:0]  smp_tag;
  logic [1:0]  avg_mode;
  logic        cal_off;
  logic        res_vld;
  logic [11:0] res_data;
  logic [4:0]  res_tag;

  int n_chk = 0;
  int n_err = 0;
  logic        got_v;
  logic [11:0] got_d;
  logic [4:0]  got_t;

  always #4 clk = ~clk;

  smp_avg_top dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld), .smp_data_i(smp_data),
    .smp_tag_i(smp_tag), .avg_mode_i(avg_mode), .cal_avg_off_i(cal_off),
    .res_vld_o(res_vld), .res_data_o(res_data), .res_tag_o(res_tag)
  );

  // {mode[19:18], tag[17:13], cal_off[12], data[11:0]}; expected output = data
  localparam logic [19:0] PASS_TAB [8] = '{
    {2'b00, 5'd0,  1'b0, 12'h000},
    {2'b00, 5'd3,  1'b0, 12'hFFF},
    {2'b00, 5'd3,  1'b1, 12'h5A5},
    {2'b00, 5'd17, 1'b0, 12'h001},
    {2'b01, 5'd8,  1'b1, 12'h7FE},
    {2'b11, 5'd8,  1'b1, 12'hABC},
    {2'b00, 5'd31, 1'b0, 12'h800},
    {2'b10, 5'd8,  1'b1, 12'h123}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setcfg(input logic [1:0] m, input logic [4:0] t, input logic o);
    avg_mode = m;
    smp_tag  = t;
    cal_off  = o;
  endtask

  task automatic put(input logic [11:0] d);
    smp_vld  = 1'b1;
    smp_data = d;
    @(negedge clk);
    got_v = res_vld;
    got_d = res_data;
    got_t = res_tag;
    smp_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    smp_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic run_block(input int n, input int seed, input bit full, input string req);
    int sum = 0;
    for (int i = 0; i < n; i++) begin
      int d = full ? 4095 : ((seed + i * 523) % 4096);
      sum += d;
      put(12'(d));
      if (i < n - 1) begin
        if (got_v !== 1'b0) chk(1'b0, req, int'(got_v), 0);
      end
    end
    chk(got_v === 1'b1, req, int'(got_v), 1);
    chk(got_d === 12'(sum / n), req, int'(got_d), sum / n);
    chk(got_t === smp_tag, {req, " R10"}, int'(got_t), int'(smp_tag));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    smp_vld = 1'b0;
    smp_data = '0;
    setcfg(2'b00, 5'd0, 1'b0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(res_vld === 1'b0, "R1", int'(res_vld), 0);
    chk(res_data === 12'd0, "R1", int'(res_data), 0);
    chk(res_tag === 5'd0, "R1", int'(res_tag), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R7: pass-through table
    for (int k = 0; k < 8; k++) begin
      string req = (PASS_TAB[k][17:13] == 5'd8) ? "R7" : "R2";
      setcfg(PASS_TAB[k][19:18], PASS_TAB[k][17:13], PASS_TAB[k][12]);
      put(PASS_TAB[k][11:0]);
      chk(got_v === 1'b1, req, int'(got_v), 1);
      chk(got_d === PASS_TAB[k][11:0], req, int'(got_d), int'(PASS_TAB[k][11:0]));
      chk(got_t === PASS_TAB[k][17:13], req, int'(got_t), int'(PASS_TAB[k][17:13]));
    end
    idle(1);
    chk(res_vld === 1'b0, "R8", int'(res_vld), 0);

    // R3: 16-deep, two back-to-back runs
    setcfg(2'b01, 5'd3, 1'b0);
    run_block(16, 11, 1'b0, "R3");
    run_block(16, 2000, 1'b0, "R3");
    // R4: 64-deep
    setcfg(2'b10, 5'd5, 1'b0);
    run_block(64, 77, 1'b0, "R4");
    // R5: 256-deep, full scale and mixed
    setcfg(2'b11, 5'd17, 1'b0);
    run_block(256, 0, 1'b1, "R5");
    run_block(256, 901, 1'b0, "R5");
    // R6: calibration tag averages 16 regardless of mode
    setcfg(2'b11, 5'd8, 1'b0);
    run_block(16, 300, 1'b0, "R6");
    setcfg(2'b00, 5'd8, 1'b0);
    run_block(16, 4000, 1'b0, "R6");
    // R11: disable bit ignored on ordinary tag
    setcfg(2'b01, 5'd2, 1'b1);
    run_block(16, 55, 1'b0, "R11");

    // R8: idle gaps between samples
    setcfg(2'b01, 5'd4, 1'b0);
    begin
      int sum = 0;
      for (int i = 0; i < 16; i++) begin
        put(12'(100 + i * 200));
        sum += 100 + i * 200;
        if (i < 15) begin
          idle(2);
          if (res_vld !== 1'b0) chk(1'b0, "R8", int'(res_vld), 0);
        end
      end
      chk(got_v === 1'b1, "R8", int'(got_v), 1);
      chk(got_d === 12'(sum / 16), "R8", int'(got_d), sum / 16);
      idle(1);
      chk(res_vld === 1'b0, "R8", int'(res_vld), 0);
    end

    // R9: tag change mid-run discards partial sum
    setcfg(2'b01, 5'd3, 1'b0);
    for (int i = 0; i < 10; i++) put(12'hFFF);
    chk(got_v === 1'b0, "R9", int'(got_v), 0);
    setcfg(2'b01, 5'd6, 1'b0);
    run_block(16, 10, 1'b0, "R9");
    // R9: mode change mid-run
    setcfg(2'b10, 5'd6, 1'b0);
    for (int i = 0; i < 30; i++) put(12'hFFF);
    setcfg(2'b01, 5'd6, 1'b0);
    run_block(16, 123, 1'b0, "R9");
    // R9: disable-bit change mid-run
    for (int i = 0; i < 10; i++) put(12'hFFF);
    setcfg(2'b01, 5'd6, 1'b1);
    run_block(16, 321, 1'b0, "R9");

    // R1: reset in mid-run clears partial sum
    setcfg(2'b01, 5'd0, 1'b0);
    for (int i = 0; i < 10; i++) put(12'hFFF);
    rst_n = 1'b0;
    @(negedge clk);
    chk(res_vld === 1'b0, "R1", int'(res_vld), 0);
    chk(res_data === 12'd0, "R1", int'(res_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_block(16, 7, 1'b0, "R1");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule